// File: doc/BRIEF.md
# Shared Work Queue with Accept/Retry Status

This block is a device-side queue of work descriptors that many unrelated software agents can write into at the same time. Each descriptor is a 512-bit (64-byte) record delivered whole in a single write. Instead of stalling a writer when the queue cannot take more work, the queue answers every status-bearing write with a one-bit reply. The reply says either that the descriptor was taken or that the writer should try again later. Because the queue never holds state for a refused write, submitters need no locks and no coordination with each other.

A mode input selects between two behaviours. In shared operation, a programmable occupancy limit caps how many entries the queue holds. Status-bearing (deferrable) writes get a reply one cycle after they arrive, in arrival order, and plain writes are ignored. In dedicated operation, a single owner posts descriptors without any reply and tracks the queue fill itself. A posted write that finds the queue full is dropped and raises a sticky error flag.

The engine side drains descriptors in arrival order through a valid/ready port. The port also presents the address-space identifier and the two completion-request flags decoded from the head entry, so every entry can be traced to the agent that submitted it.

Top module: `swq_work_queue`

## Requirements
- R1: A taken descriptor is stored as a whole 512-bit word and appears unchanged on `deq_desc`, in the order the descriptors were taken. `deq_desc` holds steady while `deq_valid` is high and `deq_ready` is low.
- R2: For the head entry, `deq_pasid` shows descriptor bits [19:0], `deq_want_irq` shows bit 20 and `deq_want_rec` shows bit 21. The two flags are independent of each other.
- R3: In shared mode (`cfg_shared`=1), each write with `wr_valid`=1 and `wr_defer`=1 produces exactly one reply with `rsp_valid`=1 on the next cycle. In that reply `rsp_retry`=0 means the descriptor was enqueued.
- R4: The effective limit in shared mode is the smaller of `cfg_limit` and DEPTH. A deferrable write gets `rsp_retry`=1 when the occupancy, minus any dequeue in the same cycle, is already at or above this limit. A refused write leaves the queue contents and occupancy unchanged.
- R5: A write that arrives in the same cycle as a dequeue, while the queue sits at its limit, is accepted.
- R6: In dedicated mode (`cfg_shared`=0), every write is posted with no reply (`rsp_valid` stays 0), whatever `wr_defer` is. It is enqueued whenever the physical depth, after any dequeue in the same cycle, has room; `cfg_limit` is ignored.
- R7: A dedicated-mode write that finds DEPTH entries and no dequeue in the same cycle is dropped. It sets `ovf_err`, which stays high until reset.
- R8: In shared mode, a write with `wr_defer`=0 is ignored: there is no reply and nothing is enqueued.
- R9: `occupancy` equals the number of entries held. `deq_valid` is high exactly when `occupancy` is nonzero, and an entry leaves on a cycle with `deq_valid` and `deq_ready` both high.
- R10: After reset the queue is empty, `rsp_valid` is 0, `deq_valid` is 0 and `ovf_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shared | input | 1 | 1 = shared operation with replies, 0 = dedicated posted operation |
| cfg_limit | input | CNT_W | Occupancy limit for shared operation (clamped to DEPTH) |
| wr_valid | input | 1 | Descriptor write present this cycle |
| wr_defer | input | 1 | Write is deferrable and expects a status reply |
| wr_desc | input | 512 | Descriptor payload |
| rsp_valid | output | 1 | Status reply present (one cycle after the write) |
| rsp_retry | output | 1 | 1 = retry later, 0 = accepted |
| deq_valid | output | 1 | Head descriptor available |
| deq_ready | input | 1 | Engine takes the head descriptor |
| deq_desc | output | 512 | Head descriptor |
| deq_pasid | output | 20 | Address-space identifier of the head descriptor |
| deq_want_irq | output | 1 | Head descriptor asks for a completion interrupt |
| deq_want_rec | output | 1 | Head descriptor asks for a completion record write |
| occupancy | output | CNT_W | Number of descriptors held |
| ovf_err | output | 1 | Sticky: a dedicated-mode write was dropped |

## Verification
Some internal faults show up on the next cycle. A wrong occupancy count or a miscomputed limit shows on the next reply as a `rsp_retry` of the wrong polarity, and on `occupancy` at once. Other faults surface later. A corrupted read or write pointer shows up only when that entry reaches the head, as a `deq_desc` or decoded field that differs from the descriptor written, possibly many cycles later. The bench therefore drains every entry and compares each head against its own ordered model. A missing same-cycle dequeue credit shows only in the narrow case of a write meeting a drain at the limit, which is driven on purpose.

// File: rtl/swq_pkg.sv
package swq_pkg;
  localparam int DESC_W   = 512;
  localparam int PASID_W  = 20;
  localparam int PASID_LO = 0;
  localparam int IRQ_BIT  = 20;
  localparam int REC_BIT  = 21;

  typedef logic [DESC_W-1:0] desc_t;

  function automatic logic [PASID_W-1:0] desc_pasid(input desc_t d);
    return d[PASID_LO +: PASID_W];
  endfunction

  function automatic logic desc_irq(input desc_t d);
    return d[IRQ_BIT];
  endfunction

  function automatic logic desc_rec(input desc_t d);
    return d[REC_BIT];
  endfunction

  // smaller of the programmed limit and the physical depth
  function automatic int unsigned clamp_limit(input int unsigned lim, input int unsigned depth);
    return (lim > depth) ? depth : lim;
  endfunction

  // room exists when the fill left after this cycle's drain is below the cap
  function automatic logic has_room(input int unsigned occ, input logic pop, input int unsigned cap);
    int unsigned left;
    left = occ - (pop ? 1 : 0);
    return left < cap;
  endfunction
endpackage

// File: rtl/swq_ring.sv
module swq_ring #(
  parameter int DEPTH = 8,
  parameter int W     = 512,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign count     = count_q;
endmodule

// File: rtl/swq_admit.sv
module swq_admit #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             wr_valid,
  input  logic             wr_defer,
  input  logic [CNT_W-1:0] occ,
  input  logic             pop,
  output logic [CNT_W-1:0] lim_eff,
  output logic             push,
  output logic             refuse,
  output logic             drop,
  output logic             rsp_valid,
  output logic             rsp_retry,
  output logic             ovf_err
);
  logic room;
  logic status_wr;
  logic posted_wr;
  logic rsp_valid_q, rsp_retry_q, ovf_q;

  always_comb begin
    lim_eff = shared ? CNT_W'(swq_pkg::clamp_limit(32'(cfg_limit), DEPTH))
                     : CNT_W'(DEPTH);
  end

  assign room      = swq_pkg::has_room(32'(occ), pop, 32'(lim_eff));
  assign status_wr = wr_valid & shared & wr_defer;
  assign posted_wr = wr_valid & ~shared;

  assign push   = (status_wr | posted_wr) & room;
  assign refuse = status_wr & ~room;
  assign drop   = posted_wr & ~room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_retry_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      rsp_valid_q <= status_wr;
      rsp_retry_q <= refuse;
      ovf_q       <= ovf_q | drop;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_retry = rsp_retry_q;
  assign ovf_err   = ovf_q;
endmodule

// File: rtl/swq_work_queue.sv
module swq_work_queue #(
  parameter int DEPTH = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int DESC_W  = swq_pkg::DESC_W,
  localparam int PASID_W = swq_pkg::PASID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_shared,
  input  logic [CNT_W-1:0]   cfg_limit,
  input  logic               wr_valid,
  input  logic               wr_defer,
  input  logic [DESC_W-1:0]  wr_desc,
  output logic               rsp_valid,
  output logic               rsp_retry,
  output logic               deq_valid,
  input  logic               deq_ready,
  output logic [DESC_W-1:0]  deq_desc,
  output logic [PASID_W-1:0] deq_pasid,
  output logic               deq_want_irq,
  output logic               deq_want_rec,
  output logic [CNT_W-1:0]   occupancy
  ,output logic              ovf_err
);
  // named internal events, observed by the bound checker
  logic             ev_pop;
  logic             ev_push;
  logic             ev_refuse;
  logic             ev_drop;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W-1:0] fill;
  logic [DESC_W-1:0] head;

  assign deq_valid = (fill != '0);
  assign ev_pop    = deq_valid & deq_ready;

  swq_admit #(.DEPTH(DEPTH)) u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .shared    (cfg_shared),
    .cfg_limit (cfg_limit),
    .wr_valid  (wr_valid),
    .wr_defer  (wr_defer),
    .occ       (fill),
    .pop       (ev_pop),
    .lim_eff   (lim_eff),
    .push      (ev_push),
    .refuse    (ev_refuse),
    .drop      (ev_drop),
    .rsp_valid (rsp_valid),
    .rsp_retry (rsp_retry),
    .ovf_err   (ovf_err)
  );

  swq_ring #(.DEPTH(DEPTH), .W(DESC_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_data (wr_desc),
    .pop       (ev_pop),
    .head_data (head),
    .count     (fill)
  );

  assign deq_desc     = head;
  assign deq_pasid    = swq_pkg::desc_pasid(head);
  assign deq_want_irq = swq_pkg::desc_irq(head);
  assign deq_want_rec = swq_pkg::desc_rec(head);
  assign occupancy    = fill;
endmodule

// File: rtl/swq_work_queue_chk.sv
module swq_work_queue_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_shared,
  input logic             wr_valid,
  input logic             wr_defer,
  input logic             rsp_valid,
  input logic             rsp_retry,
  input logic             deq_valid,
  input logic             deq_ready,
  input logic [511:0]     deq_desc,
  input logic [CNT_W-1:0] occupancy,
  input logic [CNT_W-1:0] lim_eff,
  input logic             ovf_err
);
  a_r3_reply_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shared && wr_valid && wr_defer) |=> rsp_valid);

  // R6 and R8: a reply only ever follows a shared deferrable write
  a_r6_no_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cfg_shared && wr_valid && wr_defer));

  a_r4_retry_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_retry) |->
      (occupancy == $past(occupancy) - CNT_W'($past(deq_valid && deq_ready))));

  a_r4_accept_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_retry) |->
      (($past(occupancy) - CNT_W'($past(deq_valid && deq_ready))) < $past(lim_eff)));

  a_r5_accept_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shared && wr_valid && wr_defer && deq_valid && deq_ready && occupancy <= lim_eff)
      |=> !rsp_retry);

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  a_r7_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r1_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_desc)));
endmodule

bind swq_work_queue swq_work_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_shared (cfg_shared),
  .wr_valid   (wr_valid),
  .wr_defer   (wr_defer),
  .rsp_valid  (rsp_valid),
  .rsp_retry  (rsp_retry),
  .deq_valid  (deq_valid),
  .deq_ready  (deq_ready),
  .deq_desc   (deq_desc),
  .occupancy  (occupancy),
  .lim_eff    (lim_eff),
  .ovf_err    (ovf_err)
);

// File: tb/tb_swq_work_queue.sv
`timescale 1ns/1ps
module tb_swq_work_queue;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_shared;
  logic [CW-1:0]  cfg_limit;
  logic           wr_valid, wr_defer;
  logic [511:0]   wr_desc;
  logic           rsp_valid, rsp_retry;
  logic           deq_valid, deq_ready;
  logic [511:0]   deq_desc;
  logic [19:0]    deq_pasid;
  logic           deq_want_irq, deq_want_rec;
  logic [CW-1:0]  occupancy;
  logic           ovf_err;

  swq_work_queue #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .cfg_limit(cfg_limit),
    .wr_valid(wr_valid), .wr_defer(wr_defer), .wr_desc(wr_desc),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_desc(deq_desc),
    .deq_pasid(deq_pasid), .deq_want_irq(deq_want_irq), .deq_want_rec(deq_want_rec),
    .occupancy(occupancy), .ovf_err(ovf_err)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  logic [511:0] mq[$];
  bit    exp_rv = 1'b0;
  bit    exp_rt = 1'b0;
  bit    exp_ovf = 1'b0;
  string rv_tag = "R10";

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] rand_desc();
    logic [511:0] d;
    for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic int cap_of(input bit shared, input int lim);
    if (!shared) return DEPTH;
    return (lim > DEPTH) ? DEPTH : lim;
  endfunction

  task automatic check_all();
    chk(rv_tag, 512'(rsp_valid), 512'(exp_rv));
    if (exp_rv) chk("R4", 512'(rsp_retry), 512'(exp_rt));
    chk("R9", 512'(occupancy), 512'(mq.size()));
    chk("R9", 512'(deq_valid), 512'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R1", deq_desc, mq[0]);
      chk("R2", 512'(deq_pasid), 512'(mq[0][19:0]));
      chk("R2", 512'(deq_want_irq), 512'(mq[0][20]));
      chk("R2", 512'(deq_want_rec), 512'(mq[0][21]));
    end
    chk("R7", 512'(ovf_err), 512'(exp_ovf));
  endtask

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic cyc(input bit v, input bit dfr, input bit sh, input int lim,
                     input bit rdy, input logic [511:0] d);
    bit pop, room;
    int left;
    wr_valid = v; wr_defer = dfr; cfg_shared = sh; cfg_limit = CW'(lim);
    deq_ready = rdy; wr_desc = d;
    pop  = rdy && (mq.size() != 0);
    left = mq.size() - (pop ? 1 : 0);
    room = left < cap_of(sh, lim);
    exp_rv = 1'b0; exp_rt = 1'b0;
    if (sh) begin
      rv_tag = (v && !dfr) ? "R8" : "R3";
      if (v && dfr) begin
        exp_rv = 1'b1;
        exp_rt = !room;
      end
    end else begin
      rv_tag = "R6";
      if (v && !room) exp_ovf = 1'b1;
    end
    if (pop) void'(mq.pop_front());
    if (v && room && (!sh || dfr)) mq.push_back(d);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_shared = 1'b1; cfg_limit = CW'(DEPTH);
    wr_valid = 1'b0; wr_defer = 1'b0; wr_desc = '0; deq_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", 512'(rsp_valid), 512'(0));
    chk("R10", 512'(deq_valid), 512'(0));
    chk("R10", 512'(occupancy), 512'(0));
    chk("R10", 512'(ovf_err), 512'(0));

    // shared, limit 3: three accepts then a retry (R3, R4)
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 3, 0, rand_desc());
    chk("R4", 512'(rsp_retry), 512'(1));
    // at limit with same-cycle drain: accepted (R5)
    cyc(1, 1, 1, 3, 1, rand_desc());
    chk("R5", 512'(rsp_retry), 512'(0));
    chk("R5", 512'(occupancy), 512'(3));
    // plain write in shared mode ignored (R8)
    cyc(1, 0, 1, 8, 0, rand_desc());
    chk("R8", 512'(rsp_valid), 512'(0));
    chk("R8", 512'(occupancy), 512'(3));
    // limit above depth clamps to DEPTH (R4)
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, 15, 0, rand_desc());
    chk("R4", 512'(occupancy), 512'(DEPTH));
    // dedicated, full with drain: accepted, no error (R6)
    cyc(1, 1, 0, 1, 1, rand_desc());
    chk("R6", 512'(ovf_err), 512'(0));
    // dedicated, full, no drain: dropped, sticky error (R7)
    cyc(1, 0, 0, 1, 0, rand_desc());
    chk("R7", 512'(ovf_err), 512'(1));
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 1, '0);
    chk("R7", 512'(ovf_err), 512'(1));
    chk("R9", 512'(occupancy), 512'(0));

    // constrained random
    for (int ph = 0; ph < 12; ph++) begin
      bit sh;
      int lim;
      sh  = ph[0] ? 1'b1 : ($urandom_range(0, 3) == 0);
      lim = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 1) : $urandom_range(2, 15);
      for (int i = 0; i < 200; i++) begin
        logic [511:0] d;
        d = rand_desc();
        cyc($urandom_range(0, 9) < 7, $urandom_range(0, 9) != 0, sh, lim,
            $urandom_range(0, 9) < 4, d);
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 1, 8, 1, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule